// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution Unit

This block performs the AES byte substitution in either direction. A mode input selects the forward S-box, used when encrypting, or the inverse S-box, used when decrypting. There is no 256-entry lookup table. The unit maps the byte into a two-level field representation, GF((2^4)^2). It computes the multiplicative inverse there using 4-bit field arithmetic, then maps the result back to the byte field, which is reduced by x^8+x^4+x^3+x+1. An affine transform over GF(2) is applied after the inversion in forward mode and before it in inverse mode.

In the composite representation a byte is a linear polynomial ah·X + al. The two coefficients are 4-bit elements of GF(2^4), built on x^4+x+1. Products are reduced by X^2 + X + {e}. The fixed 8x8 bit matrices that change basis are derived at elaboration from the two field polynomials.

The unit captures a byte and its mode bit whenever the input strobe is high. The substituted byte is presented on the clock after that capture.

Top module: `aes_tower_sbox`

## Requirements
- R1: With mode 0 (forward), the result for every input byte b equals the AES substitution: the inverse of b in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine transform s_i = b_i ^ b_(i+4) ^ b_(i+5) ^ b_(i+6) ^ b_(i+7) ^ c_i with c = 0x63 (indices mod 8).
- R2: With mode 1 (inverse), the result for every byte first applies the inverse affine transform t_i = a_(i+2) ^ a_(i+5) ^ a_(i+7) ^ d_i with d = 0x05, then the same field inversion, so it undoes R1 for all 256 values.
- R3: The field inversion maps zero to zero, so forward 0x00 gives 0x63 and inverse 0x63 gives 0x00.
- R4: In forward mode the result never equals the input byte and never equals its bitwise complement.
- R5: out_valid equals in_valid delayed by one clock, and the byte captured with in_valid high is substituted and presented on out_byte in the following cycle.
- R6: The mode bit is captured together with the data, so changing in_mode while in_valid is low does not change out_byte.
- R7: While in_valid is low, the held byte is unchanged and out_byte keeps its last value whatever in_byte carries.
- R8: While rst_n is low and in the cycle after, out_valid is 0. The held byte clears to 0x00 with forward mode, so out_byte reads 0x63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Captures in_byte and in_mode at the clock edge |
| in_mode | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result on out_byte belongs to a byte accepted on the previous edge |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench applies a short table of well-known substitution pairs in both directions. It then sweeps all 256 bytes in each mode and compares against a table it builds itself by brute-force field inversion. A basis matrix or reduction constant that is wrong on even one coefficient shows up as a mismatch on some byte, which a few sample values alone could miss.

Zero and 0x63 are exercised separately, because they are the only values that bypass true inversion. Directed sequences toggle in_valid, in_mode and in_byte between captures. These sequences separate a correct capture register from one that follows the live inputs or loads without the strobe.

// File: rtl/aes_tower_pkg.sv
// Package: field constants and elaboration-time helpers for the tower-field
// byte substitution unit. Assumes the byte field polynomial 0x11B and the
// nibble field polynomial x^4+x+1; basis-change matrices are derived here.
package aes_tower_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int MAT_W  = BYTE_W * BYTE_W;

    localparam logic [BYTE_W-1:0] FWD_AFFINE_C = 8'h63;
    localparam logic [BYTE_W-1:0] INV_AFFINE_C = 8'h05;
    localparam logic [NIB_W-1:0]  QUAD_E       = 4'he;

    // Multiply in GF(2^8) modulo x^8+x^4+x^3+x+1.
    function automatic logic [BYTE_W-1:0] gf8_mul(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ((sh << 1) ^ 8'h1b) : (sh << 1);
        end
        return acc;
    endfunction

    // Multiply in GF(2^4) modulo x^4+x+1.
    function automatic logic [NIB_W-1:0] gf16_mul(input logic [NIB_W-1:0] a,
                                                  input logic [NIB_W-1:0] b);
        logic [NIB_W-1:0] acc;
        logic [NIB_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[3] ? ((sh << 1) ^ 4'h3) : (sh << 1);
        end
        return acc;
    endfunction

    // Linear map: XOR of the matrix columns selected by the set bits of v.
    function automatic logic [BYTE_W-1:0] mat_apply(input logic [MAT_W-1:0] m,
                                                    input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int i = 0; i < BYTE_W; i++)
            if (v[i]) r = r ^ m[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    // Columns are byte-field images of the tower basis {w^k, w^k*X}.
    function automatic logic [MAT_W-1:0] build_tower_to_byte();
        logic [BYTE_W-1:0] w, x, e_img, p, pw;
        logic              got_w, got_x;
        logic [MAT_W-1:0]  m;
        w = '0; x = '0; got_w = 1'b0; got_x = 1'b0;
        for (int c = 2; c < 256; c++) begin
            p = BYTE_W'(c);
            if (!got_w && ((gf8_mul(gf8_mul(p, p), gf8_mul(p, p)) ^ p ^ 8'h01) == 8'h00)) begin
                w = p;
                got_w = 1'b1;
            end
        end
        e_img = '0;
        pw = 8'h01;
        for (int k = 0; k < NIB_W; k++) begin
            if (QUAD_E[k]) e_img = e_img ^ pw;
            pw = gf8_mul(pw, w);
        end
        for (int c = 2; c < 256; c++) begin
            p = BYTE_W'(c);
            if (!got_x && ((gf8_mul(p, p) ^ p ^ e_img) == 8'h00)) begin
                x = p;
                got_x = 1'b1;
            end
        end
        pw = 8'h01;
        m  = '0;
        for (int k = 0; k < NIB_W; k++) begin
            m[k*BYTE_W +: BYTE_W]           = pw;
            m[(k+NIB_W)*BYTE_W +: BYTE_W]   = gf8_mul(pw, x);
            pw = gf8_mul(pw, w);
        end
        return m;
    endfunction

    // Inverse of a bijective 8x8 map by searching the preimage of each unit vector.
    function automatic logic [MAT_W-1:0] invert_map(input logic [MAT_W-1:0] m);
        logic [MAT_W-1:0]  r;
        logic [BYTE_W-1:0] unit;
        r = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            unit = BYTE_W'(1) << i;
            for (int v = 0; v < 256; v++)
                if (mat_apply(m, BYTE_W'(v)) == unit) r[i*BYTE_W +: BYTE_W] = BYTE_W'(v);
        end
        return r;
    endfunction

    localparam logic [MAT_W-1:0] TOWER_TO_BYTE = build_tower_to_byte();
    localparam logic [MAT_W-1:0] BYTE_TO_TOWER = invert_map(TOWER_TO_BYTE);

endpackage

// File: rtl/aes_tower_gf16_inv.sv
// Module: inverse of one GF(2^4) element (x^4+x+1); zero maps to zero.
// Assumes a purely combinational use; the search unrolls into a 16-way mux.
module aes_tower_gf16_inv
    import aes_tower_pkg::*;
(
    input  logic [NIB_W-1:0] nib_in,
    output logic [NIB_W-1:0] nib_inv
);

    // Select the unique partner whose product with the input is one.
    always_comb begin
        nib_inv = '0;
        for (int b = 1; b < (1 << NIB_W); b++)
            if (gf16_mul(nib_in, NIB_W'(b)) == 4'h1) nib_inv = NIB_W'(b);
    end

endmodule

// File: rtl/aes_tower_field_inv.sv
// Module: GF(2^8) multiplicative inverse through GF((2^4)^2) with X^2+X+{e}.
// Assumes the basis matrices from the package; zero maps to zero.
module aes_tower_field_inv
    import aes_tower_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_inv
);

    logic [BYTE_W-1:0] tower;
    logic [NIB_W-1:0]  hi, lo, norm, norm_inv, res_hi, res_lo;

    // Change basis and form the norm ah^2*e + ah*al + al^2.
    always_comb begin
        tower = mat_apply(BYTE_TO_TOWER, byte_in);
        hi    = tower[BYTE_W-1:NIB_W];
        lo    = tower[NIB_W-1:0];
        norm  = gf16_mul(gf16_mul(hi, hi), QUAD_E) ^ gf16_mul(hi, lo) ^ gf16_mul(lo, lo);
    end

    aes_tower_gf16_inv u_norm_inv (
        .nib_in  (norm),
        .nib_inv (norm_inv)
    );

    // Build the two-term inverse and map it back to the byte field.
    always_comb begin
        res_hi   = gf16_mul(hi, norm_inv);
        res_lo   = gf16_mul(hi ^ lo, norm_inv);
        byte_inv = mat_apply(TOWER_TO_BYTE, {res_hi, res_lo});
    end

endmodule

// File: rtl/aes_tower_affine.sv
// Module: AES affine transform over GF(2); INVERSE selects the backward form.
// Assumes bit 0 is the least significant bit of the byte.
module aes_tower_affine
    import aes_tower_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BYTE_W-1:0] aff_in,
    output logic [BYTE_W-1:0] aff_out
);

    generate
        if (INVERSE) begin : g_backward
            for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
                assign aff_out[i] = aff_in[(i+2)%BYTE_W] ^ aff_in[(i+5)%BYTE_W]
                                  ^ aff_in[(i+7)%BYTE_W] ^ INV_AFFINE_C[i];
            end
        end else begin : g_forward
            for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
                assign aff_out[i] = aff_in[i] ^ aff_in[(i+4)%BYTE_W] ^ aff_in[(i+5)%BYTE_W]
                                  ^ aff_in[(i+6)%BYTE_W] ^ aff_in[(i+7)%BYTE_W]
                                  ^ FWD_AFFINE_C[i];
            end
        end
    endgenerate

endmodule

// File: rtl/aes_tower_sbox.sv
// Module: forward/inverse AES S-box with a capture register at the input.
// Assumes synchronous active-low reset; the result follows the capture edge.
module aes_tower_sbox
    import aes_tower_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);

    logic [BYTE_W-1:0] held_byte;
    logic              held_mode;
    logic              held_valid;
    logic [BYTE_W-1:0] unaffine_byte, inv_src, inv_res, fwd_res;

    // Capture byte and mode on a strobe; valid is a one-cycle delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_byte  <= '0;
            held_mode  <= 1'b0;
            held_valid <= 1'b0;
        end else begin
            held_valid <= in_valid;
            if (in_valid) begin
                held_byte <= in_byte;
                held_mode <= in_mode;
            end
        end
    end

    aes_tower_affine #(.INVERSE(1'b1)) u_pre_affine (
        .aff_in  (held_byte),
        .aff_out (unaffine_byte)
    );

    // Inverse mode undoes the affine step before inverting.
    always_comb inv_src = held_mode ? unaffine_byte : held_byte;

    aes_tower_field_inv u_field_inv (
        .byte_in  (inv_src),
        .byte_inv (inv_res)
    );

    aes_tower_affine #(.INVERSE(1'b0)) u_post_affine (
        .aff_in  (inv_res),
        .aff_out (fwd_res)
    );

    // Forward mode applies the affine step after inverting.
    always_comb out_byte = held_mode ? inv_res : fwd_res;

    assign out_valid = held_valid;

endmodule

// File: rtl/aes_tower_sbox_chk.sv
// Checker: temporal properties of the substitution unit at its ports.
module aes_tower_sbox_chk (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_mode,
    input  logic [7:0] in_byte,
    input  logic       out_valid,
    input  logic [7:0] out_byte
);

    a_r5_valid_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r5_idle_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r3_zero_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_byte == 8'h00) |=> (out_byte == 8'h63));

    a_r3_zero_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && in_byte == 8'h63) |=> (out_byte == 8'h00));

    a_r4_no_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode) |=> (out_byte != $past(in_byte) && out_byte != ~$past(in_byte)));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_byte));

    a_r8_reset_clears_valid: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind aes_tower_sbox aes_tower_sbox_chk u_chk (.*);

// File: tb/aes_tower_sbox_bench.sv
`timescale 1ns/1ps
module aes_tower_sbox_bench;

    localparam real HALF_PERIOD = 2.5;
    localparam int  N_VEC = 10;
    // {mode, input, expected}
    localparam logic [16:0] VECS [N_VEC] = '{
        {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7c}, {1'b0, 8'h02, 8'h77},
        {1'b0, 8'h10, 8'hca}, {1'b0, 8'h53, 8'hed}, {1'b0, 8'hff, 8'h16},
        {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7c, 8'h01}, {1'b1, 8'hed, 8'h53},
        {1'b1, 8'h16, 8'hff}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_mode = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] fwd_tab [256];
    logic [7:0] inv_tab [256];

    always #(HALF_PERIOD) clk = ~clk;

    aes_tower_sbox u_aes_tower_sbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= s;
            s = s[7] ? ((s << 1) ^ 8'h1b) : (s << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic m, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_mode  = m;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(HALF_PERIOD * 2 * 100000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // Behavioural tables: brute-force inverse then affine with rotations.
        for (int a = 0; a < 256; a++) begin
            logic [7:0] iv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (ref_mul(8'(a), 8'(b)) == 8'h01) iv = 8'(b);
            fwd_tab[a] = iv ^ rotl(iv, 1) ^ rotl(iv, 2) ^ rotl(iv, 3) ^ rotl(iv, 4) ^ 8'h63;
        end
        for (int a = 0; a < 256; a++) inv_tab[fwd_tab[a]] = 8'(a);

        // R8: reset state.
        repeat (3) @(posedge clk);
        #1;
        check("R8 valid in reset", {7'b0, out_valid}, 8'h00);
        check("R8 byte in reset", out_byte, 8'h63);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R8 valid after reset", {7'b0, out_valid}, 8'h00);

        // Known vectors, R1/R2/R3.
        for (int i = 0; i < N_VEC; i++) begin
            drive(1'b1, VECS[i][16], VECS[i][15:8]);
            check(VECS[i][16] ? "R2 vector" : "R1 vector", out_byte, VECS[i][7:0]);
        end

        // R1 and R4: full forward sweep.
        for (int a = 0; a < 256; a++) begin
            drive(1'b1, 1'b0, 8'(a));
            check("R1 sweep", out_byte, fwd_tab[a]);
            check("R4 no fixed point", {7'b0, (out_byte == 8'(a)) || (out_byte == ~8'(a))}, 8'h00);
            check("R5 valid", {7'b0, out_valid}, 8'h01);
        end

        // R2: full inverse sweep.
        for (int a = 0; a < 256; a++) begin
            drive(1'b1, 1'b1, 8'(a));
            check("R2 sweep", out_byte, inv_tab[a]);
        end

        // R3: zero handling in both directions.
        drive(1'b1, 1'b0, 8'h00);
        check("R3 zero forward", out_byte, 8'h63);
        drive(1'b1, 1'b1, 8'h63);
        check("R3 zero inverse", out_byte, 8'h00);

        // R5/R7: idle cycle drops valid and holds the byte.
        drive(1'b1, 1'b0, 8'h53);
        check("R5 capture result", out_byte, 8'hed);
        drive(1'b0, 1'b0, 8'h00);
        check("R5 valid drops", {7'b0, out_valid}, 8'h00);
        check("R7 hold byte", out_byte, 8'hed);
        drive(1'b0, 1'b0, 8'hff);
        check("R7 hold byte again", out_byte, 8'hed);

        // R6: mode captured with data; later mode change is ignored.
        drive(1'b1, 1'b1, 8'hed);
        check("R6 inverse captured", out_byte, 8'h53);
        drive(1'b0, 1'b0, 8'hed);
        check("R6 mode change ignored", out_byte, 8'h53);
        drive(1'b1, 1'b0, 8'hed);
        check("R6 new mode captured", out_byte, fwd_tab[8'hed]);
        check("R5 valid returns", {7'b0, out_valid}, 8'h01);

        // R8: reset mid-run clears state.
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R8 valid on reset", {7'b0, out_valid}, 8'h00);
        check("R8 byte on reset", out_byte, 8'h63);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule